// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

The controller gathers event lines from eleven 32-bit second-level groups and folds them into one 32-bit top-level summary word. This word drives a single-cycle interrupt pulse. Each group holds a mask, a pending (identity) word and an enable word, and it can read back the raw event levels. An event bit becomes pending only when its mask bit is clear. The pending bits that are also enabled form the group's contribution. Each contribution lights one or two fixed bits of the summary word, depending on whether its lower half, its upper half or its full word is checked.

Software reaches every register through a flat, word-addressed write and read port. The only writable bit of the summary word is its top bit, which acts as the global interrupt enable. The output pulses when that enable is set, at least one summary bit is set and the condition is newly true. It pulses again whenever a configuration write or a newly accepted event causes a fresh evaluation while the condition holds.

Top module: `irqagg_top`

## Requirements
- R1: After reset every mask word reads 0xFFFFFFFF, every pending word, every enable word and the summary word read 0, and `irq_o` is low.
- R2: Group g occupies byte addresses g*0x10 to g*0x10+0xC. Offset +0x0 reads the group's raw `evt_i` slice (bits g*32 to g*32+31), and writes to it are ignored.
- R3: Offset +0x4 is the mask word. An `evt_i` bit that is high at a clock edge while its mask bit is 0 sets the pending bit. If the mask bit is 1, the pending word stays unchanged.
- R4: Offset +0x8 is the pending word. A write clears each bit written as 1 and keeps each bit written as 0. An accepted event in the same cycle leaves its bit set.
- R5: Offset +0xC is the enable word, and the contribution is pending AND enable. Summary bits follow the contributions at once, as below, and a bit clears when its slice has no contribution:
  - group 0: low half to bit 0, high half to bit 1
  - group 1: low half to bit 2, high half to bit 3
  - group 2: low half to bit 4
  - group 3: low half to bit 6
  - groups 4, 5 and 6: full word to bits 16, 17 and 18
  - group 7: full word to bit 20
  - group 8: full word to bit 22
  - group 9: full word to bit 23
  - group 10: full word to bit 30
- R6: The summary word is at byte address 0xB0. A write stores only data bit 31 as the global enable, and bits 30:0 read back the summaries.
- R7: `irq_o` is high only when the global enable is 1 and at least one summary bit is 1.
- R8: `irq_o` is high for exactly one cycle, in the cycle after the edge at which the condition of R7 becomes true.
- R9: While the condition holds, a write to any mask, enable or summary word, or an accepted event, gives one more pulse in the following cycle. A pending-word write does not.
- R10: Addresses with low two bits not 00 are unmapped. So are addresses above 0xB0, and the words in block 11 other than 0xB0. Writes to them have no effect, and reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 352 | Event lines, 32 per group, group g at bits g*32 and up |
| wr_en_i | input | 1 | Write strobe for the register at addr_i |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Single-cycle interrupt pulse |

## Verification
On every cycle the assertions check three things in each group: acceptance of unmasked events, the holding of masked bits, and clear-on-write with event priority. In the top level they check that the global enable follows writes, that a pulse always sits under an enabled, non-empty summary, that the pulse appears on each rising edge of that condition, and that back-to-back pulses need a re-evaluation cause. Some behaviour can only be shown by the directed scenarios: the exact bit each group and half lands in, the read-back of raw levels, the ignored writes and unmapped addresses, and the absence of a pulse after a pending-word write.

// File: rtl/irqagg_pkg.sv
`timescale 1ns/1ps
package irqagg_pkg;
  localparam int unsigned GRP_W      = 32;
  localparam int unsigned NUM_GRP    = 11;
  localparam int unsigned GLB_EN_BIT = GRP_W - 1;

  typedef logic [GRP_W-1:0] word_t;

  typedef enum logic [1:0] {
    SLOT_STATUS = 2'd0,
    SLOT_MASK   = 2'd1,
    SLOT_IDENT  = 2'd2,
    SLOT_ENABLE = 2'd3
  } slot_e;

  localparam word_t LO_HALF = 32'h0000_FFFF;
  localparam word_t HI_HALF = 32'hFFFF_0000;
  localparam word_t FULL    = 32'hFFFF_FFFF;

  // Which group feeds summary bit m (NUM_GRP when none does)
  function automatic int unsigned src_grp(input int unsigned m);
    case (m)
      0, 1:    src_grp = 0;
      2, 3:    src_grp = 1;
      4:       src_grp = 2;
      6:       src_grp = 3;
      16:      src_grp = 4;
      17:      src_grp = 5;
      18:      src_grp = 6;
      20:      src_grp = 7;
      22:      src_grp = 8;
      23:      src_grp = 9;
      30:      src_grp = 10;
      default: src_grp = NUM_GRP;
    endcase
  endfunction

  // Slice of the group word checked by summary bit m
  function automatic word_t src_mask(input int unsigned m);
    case (m)
      0, 2, 4, 6: src_mask = LO_HALF;
      1, 3:       src_mask = HI_HALF;
      default:    src_mask = FULL;
    endcase
  endfunction

  function automatic word_t fold_summary(input word_t contrib [NUM_GRP]);
    word_t       s;
    int unsigned g;
    s = '0;
    for (int unsigned m = 0; m < GLB_EN_BIT; m++) begin
      g = src_grp(m);
      if (g < NUM_GRP) s[m] = |(contrib[g] & src_mask(m));
    end
    return s;
  endfunction

  function automatic word_t latch_next(input word_t cur, input word_t clr,
                                       input word_t evt, input word_t mask);
    return (cur & ~clr) | (evt & ~mask);
  endfunction
endpackage

// File: rtl/irqagg_group.sv
`timescale 1ns/1ps
module irqagg_group
  import irqagg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  word_t evt_i,
  input  logic  wr_mask_i,
  input  logic  wr_ident_i,
  input  logic  wr_enable_i,
  input  word_t wdata_i,
  output word_t mask_o,
  output word_t ident_o,
  output word_t enable_o,
  output word_t contrib_o,
  output logic  accept_o
);
  word_t accepted;
  word_t clr;

  assign accepted = evt_i & ~mask_o;
  assign accept_o = |accepted;
  assign clr      = wr_ident_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o   <= '1;
      ident_o  <= '0;
      enable_o <= '0;
    end else begin
      if (wr_mask_i)   mask_o   <= wdata_i;
      if (wr_enable_i) enable_o <= wdata_i;
      ident_o <= latch_next(ident_o, clr, evt_i, mask_o);
    end
  end

  assign contrib_o = ident_o & enable_o;

  AST_ACCEPT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> ((ident_o & $past(accepted)) == $past(accepted))); // R3
  AST_MASKED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ident_o & ~$past(ident_o) & $past(mask_o)) == '0)); // R3
  AST_CLEAR_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ident_i |=> ((ident_o & $past(wdata_i) & ~$past(accepted)) == '0)); // R4
endmodule

// File: rtl/irqagg_master.sv
`timescale 1ns/1ps
module irqagg_master
  import irqagg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  word_t contrib_i [NUM_GRP],
  input  logic  wr_master_i,
  input  logic  en_wdata_i,
  input  logic  reeval_i,
  output word_t master_o,
  output logic  irq_o
);
  word_t summary;
  logic  glb_en_q;
  logic  cond;
  logic  cond_q;
  logic  reeval_q;

  assign summary = fold_summary(contrib_i);
  assign cond    = glb_en_q && (summary != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_en_q <= 1'b0;
      cond_q   <= 1'b0;
      reeval_q <= 1'b0;
    end else begin
      if (wr_master_i) glb_en_q <= en_wdata_i;
      cond_q   <= cond;
      reeval_q <= reeval_i;
    end
  end

  assign irq_o = cond && (!cond_q || reeval_q);

  always_comb begin
    master_o             = summary;
    master_o[GLB_EN_BIT] = glb_en_q;
  end

  AST_GLB_EN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_master_i |=> (master_o[GLB_EN_BIT] == $past(en_wdata_i))); // R6
  AST_PULSE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (master_o[GLB_EN_BIT] && (master_o[GLB_EN_BIT-1:0] != '0))); // R7
  AST_PULSE_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cond) |-> irq_o); // R8
  AST_REPULSE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && $past(irq_o)) |-> $past(reeval_i)); // R9
endmodule

// File: rtl/irqagg_top.sv
`timescale 1ns/1ps
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_GRP*GRP_W-1:0] evt_i,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [GRP_W-1:0]         wdata_i,
  output logic [GRP_W-1:0]         rdata_o,
  output logic                     irq_o
);
  localparam int unsigned BLK_W   = ADDR_W - 4;
  localparam int unsigned MST_BLK = NUM_GRP;

  logic [BLK_W-1:0] blk;
  logic [1:0]       slot;
  logic             aligned;
  int unsigned      blk_n;
  logic             grp_hit;
  logic             mst_hit;

  assign blk     = addr_i[ADDR_W-1:4];
  assign slot    = addr_i[3:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign blk_n   = 32'(blk);
  assign grp_hit = aligned && (blk_n < NUM_GRP);
  assign mst_hit = aligned && (blk_n == MST_BLK) && (slot == SLOT_STATUS);

  word_t evt_a     [NUM_GRP];
  word_t mask_a    [NUM_GRP];
  word_t ident_a   [NUM_GRP];
  word_t enable_a  [NUM_GRP];
  word_t contrib_a [NUM_GRP];
  logic [NUM_GRP-1:0] accept_a;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic sel;
    assign sel      = wr_en_i && grp_hit && (blk_n == int'(g));
    assign evt_a[g] = evt_i[g*GRP_W +: GRP_W];

    irqagg_group u_grp (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .evt_i       (evt_a[g]),
      .wr_mask_i   (sel && (slot == SLOT_MASK)),
      .wr_ident_i  (sel && (slot == SLOT_IDENT)),
      .wr_enable_i (sel && (slot == SLOT_ENABLE)),
      .wdata_i     (wdata_i),
      .mask_o      (mask_a[g]),
      .ident_o     (ident_a[g]),
      .enable_o    (enable_a[g]),
      .contrib_o   (contrib_a[g]),
      .accept_o    (accept_a[g])
    );
  end

  logic  cfg_wr;
  logic  reeval;
  word_t master;

  assign cfg_wr = wr_en_i && ((grp_hit && ((slot == SLOT_MASK) || (slot == SLOT_ENABLE)))
                              || mst_hit);
  assign reeval = cfg_wr || (|accept_a);

  irqagg_master u_master (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .contrib_i   (contrib_a),
    .wr_master_i (wr_en_i && mst_hit),
    .en_wdata_i  (wdata_i[GLB_EN_BIT]),
    .reeval_i    (reeval),
    .master_o    (master),
    .irq_o       (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (grp_hit) begin
      case (slot)
        SLOT_STATUS: rdata_o = evt_a[blk];
        SLOT_MASK:   rdata_o = mask_a[blk];
        SLOT_IDENT:  rdata_o = ident_a[blk];
        default:     rdata_o = enable_a[blk];
      endcase
    end else if (mst_hit) begin
      rdata_o = master;
    end
  end
endmodule

// File: tb/test_irqagg_top.sv
`timescale 1ns/1ps
module test_irqagg_top;
  localparam int NG = 11;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NG*32-1:0]  evt = '0;
  logic              wr_en = 1'b0;
  logic [7:0]        addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              irq;

  int n_chk = 0;
  int n_fail = 0;
  logic pulse_seen;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  irqagg_top i_irqagg_top (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  localparam logic [7:0] MST = 8'hB0;

  function automatic logic [7:0] ra(input int g, input int s);
    return 8'(g*16 + s*4);
  endfunction

  function automatic int lo_bit(input int g);
    case (g)
      0: return 0;   1: return 2;   2: return 4;   3: return 6;
      4: return 16;  5: return 17;  6: return 18;  7: return 20;
      8: return 22;  9: return 23;  default: return 30;
    endcase
  endfunction

  function automatic int hi_bit(input int g);
    case (g)
      0: return 1;
      1: return 3;
      2, 3: return -1;
      default: return lo_bit(g);
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 pulse_seen = irq;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic fire(input int g, input logic [31:0] bits);
    @(negedge clk);
    evt[g*32 +: 32] = bits;
    @(posedge clk); #1 pulse_seen = irq;
    @(negedge clk);
    evt[g*32 +: 32] = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1 pulse_seen = irq;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(ra(0, 1), d);  chk("R1 mask g0", d, 32'hFFFF_FFFF);
    rd(ra(10, 1), d); chk("R1 mask g10", d, 32'hFFFF_FFFF);
    rd(ra(5, 2), d);  chk("R1 ident g5", d, 0);
    rd(ra(7, 3), d);  chk("R1 enable g7", d, 0);
    rd(MST, d);       chk("R1 master", d, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    @(negedge clk); evt[2*32 +: 32] = 32'hA5A5_0001;
    rd(ra(2, 0), d); chk("R2 status raw", d, 32'hA5A5_0001);
    wr(ra(2, 0), 32'h1234_5678);
    rd(ra(2, 0), d); chk("R2 status write ignored", d, 32'hA5A5_0001);
    rd(ra(2, 2), d); chk("R3 masked event ignored", d, 0);
    @(negedge clk); evt[2*32 +: 32] = '0;
    rd(ra(2, 0), d); chk("R2 status follows input", d, 0);
  endtask

  task automatic t_latch();
    logic [31:0] d;
    wr(ra(0, 1), 32'hFFFF_FFFE);
    rd(ra(0, 1), d); chk("R3 mask readback", d, 32'hFFFF_FFFE);
    fire(0, 32'h3);
    rd(ra(0, 2), d); chk("R3 only unmasked bit latched", d, 32'h1);
    fire(0, 32'h2);
    rd(ra(0, 2), d); chk("R3 masked bit leaves ident", d, 32'h1);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(ra(0, 2), 32'h0);
    rd(ra(0, 2), d); chk("R4 zero write keeps", d, 32'h1);
    @(negedge clk);
    wr_en = 1'b1; addr = ra(0, 2); wdata = 32'h1; evt[0 +: 32] = 32'h1;
    @(negedge clk);
    wr_en = 1'b0; evt[0 +: 32] = '0;
    rd(ra(0, 2), d); chk("R4 event beats clear", d, 32'h1);
    wr(ra(0, 2), 32'h1);
    rd(ra(0, 2), d); chk("R4 one write clears", d, 32'h0);
    wr(ra(0, 1), 32'hFFFF_FFFF);
  endtask

  task automatic t_map();
    logic [31:0] d;
    logic [31:0] e;
    for (int g = 0; g < NG; g++) begin
      wr(ra(g, 1), 32'h0);
      wr(ra(g, 3), 32'hFFFF_FFFF);
      fire(g, 32'h0000_0100);
      chk("R7 no pulse when disabled", 32'(pulse_seen), 0);
      rd(MST, d); chk("R5 low half summary", d, 32'h1 << lo_bit(g));
      wr(ra(g, 2), 32'hFFFF_FFFF);
      fire(g, 32'h0100_0000);
      e = (hi_bit(g) < 0) ? 32'h0 : (32'h1 << hi_bit(g));
      rd(MST, d); chk("R5 high half summary", d, e);
      wr(ra(g, 3), 32'h0);
      rd(MST, d); chk("R5 enable gates summary", d, 32'h0);
      rd(ra(g, 2), d); chk("R5 ident kept", d, 32'h0100_0000);
      wr(ra(g, 2), 32'hFFFF_FFFF);
      wr(ra(g, 1), 32'hFFFF_FFFF);
    end
  endtask

  task automatic t_master();
    logic [31:0] d;
    wr(MST, 32'hFFFF_FFFF);
    chk("R7 no pulse without summary", 32'(pulse_seen), 0);
    rd(MST, d); chk("R6 only bit31 writable", d, 32'h8000_0000);
    wr(MST, 32'h0);
    rd(MST, d); chk("R6 enable cleared", d, 32'h0);
  endtask

  task automatic t_pulse();
    logic [31:0] d;
    wr(MST, 32'h8000_0000);
    wr(ra(4, 1), 32'h0);
    wr(ra(4, 3), 32'h1);
    chk("R7 no pulse nothing pending", 32'(pulse_seen), 0);
    fire(4, 32'h1);
    chk("R8 pulse on rise", 32'(pulse_seen), 1);
    tick(); chk("R8 pulse one cycle", 32'(pulse_seen), 0);
    tick(); chk("R8 stays low", 32'(pulse_seen), 0);
    fire(4, 32'h2);
    chk("R9 accepted event repulses", 32'(pulse_seen), 1);
    tick(); chk("R9 repulse one cycle", 32'(pulse_seen), 0);
    wr(ra(4, 3), 32'h1);
    chk("R9 enable write repulses", 32'(pulse_seen), 1);
    wr(ra(4, 1), 32'h0);
    chk("R9 mask write repulses", 32'(pulse_seen), 1);
    wr(ra(4, 2), 32'h2);
    chk("R9 ident write no pulse", 32'(pulse_seen), 0);
    wr(MST, 32'h0);
    chk("R7 disable stops pulse", 32'(pulse_seen), 0);
    rd(MST, d); chk("R6 summary remains", d, 32'h0001_0000);
    wr(MST, 32'h8000_0000);
    chk("R8 enable rise pulses", 32'(pulse_seen), 1);
    wr(ra(4, 2), 32'hFFFF_FFFF);
    chk("R7 cleared no pulse", 32'(pulse_seen), 0);
    rd(MST, d); chk("R5 clear drops summary", d, 32'h8000_0000);
    wr(ra(4, 3), 32'h0);
    wr(ra(4, 1), 32'hFFFF_FFFF);
    wr(MST, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'hC0, 32'hFFFF_FFFF);
    rd(8'hC0, d); chk("R10 above master reads 0", d, 0);
    wr(8'hB4, 32'hFFFF_FFFF);
    rd(8'hB4, d); chk("R10 block 11 other word reads 0", d, 0);
    rd(MST, d); chk("R10 master untouched", d, 0);
    wr(8'h05, 32'h0);
    rd(ra(0, 1), d); chk("R10 misaligned write ignored", d, 32'hFFFF_FFFF);
    rd(8'h05, d); chk("R10 misaligned read 0", d, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_status();
    t_latch();
    t_clear();
    t_map();
    t_master();
    t_pulse();
    t_unmapped();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule